// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Clock Generator

This block turns one fast reference clock into the two processor clock phases, `phi1` and `phi2`, that may never be high together, plus a system clock at the same divided rate. With the default divisor of nine, an 18 MHz reference gives 2 MHz on all three outputs. Each period is nine reference cycles. `phi1` is high for two of them and `phi2` for five. A single dead cycle sits after each phase, so there is always a gap between the two.

The block also conditions two raw asynchronous inputs for the processor. A reset request sets the reset output at once. The output is released only when the request has been gone for a full period or more, and only on the edge that starts a `phi2` pulse. A ready input is synchronized and then presented only at the start of each `phi2` pulse, so the processor sees a level that never moves inside a phase.

The phase sequencer is a state machine with four states: `SEQ_P1` (phi1 high), `SEQ_GAP1` (dead cycle), `SEQ_P2` (phi2 high) and `SEQ_GAP2` (dead cycle). The transitions `SEQ_P1`→`SEQ_GAP1`→`SEQ_P2`→`SEQ_GAP2`→`SEQ_P1` are taken when the modulo-nine count crosses 2, 3, 8 and 0. The reset conditioner has three states:
- `RC_SYNC`: the synchronized request is still high.
- `RC_HOLD`: the minimum hold time is being counted.
- `RC_RUN`: reset is released.

It moves `RC_SYNC`→`RC_HOLD` when the synchronized request drops. It moves `RC_HOLD`→`RC_RUN` when the hold time is complete and a `phi2` pulse is starting. Any state returns to `RC_SYNC` while the synchronized request is high.

Top module: `phase_clkgen`

## Requirements
- R1: `phi1`, `phi2` and `sys_clk` each repeat with a period of exactly DIV (default 9) reference cycles. The reset input does not stop or shift them.
- R2: `phi1` and `phi2` are never high in the same cycle. At least one reference cycle with both low separates the fall of either phase from the rise of the other.
- R3: Counting from the reference edge where `phi1` rises as count 0, `phi1` is high for counts 0 and 1 (P1_LEN = 2 cycles).
- R4: `phi2` is high for counts 3 to 7 (P2_LEN = 5 cycles). Counts 2 and 8 are dead cycles.
- R5: `sys_clk` is high for counts 0 to 4 and low for counts 5 to 8, and it rises on the same edge as `phi1`.
- R6: While `rst_req` is high, `rst_out` is high. It is set asynchronously, without waiting for a clock edge.
- R7: After `rst_req` falls, `rst_out` falls on the first reference edge that is both at least DIV+3 edges after the fall and an edge where `phi2` rises (count 3). It never falls at any other edge.
- R8: `rdy_out` changes only on edges where `phi2` rises. There it takes the level `rdy_raw` had at the reference edge two edges earlier. A pulse on `rdy_raw` that misses that sampling edge has no effect on `rdy_out`.
- R9: While `rst_req` is high, `rdy_out` is 0 and the ready synchronizer is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Fast reference clock; all state is clocked on its rising edge |
| rst_req | input | 1 | Asynchronous reset request, active high |
| rdy_raw | input | 1 | Asynchronous ready level from the system |
| phi1 | output | 1 | First processor clock phase |
| phi2 | output | 1 | Second processor clock phase |
| sys_clk | output | 1 | System clock at the divided rate |
| rst_out | output | 1 | Conditioned reset, active high, released at a phi2 start |
| rdy_out | output | 1 | Conditioned ready, updated at each phi2 start |

## Verification
The reset release and the ready update both happen only on the edge where `phi2` rises, so both outputs can change on the same reference edge. The bench provokes this by raising `rdy_raw` just before the sampling edge that feeds the first `phi2` rise on which reset can be released. The earlier `phi2` rises inside the hold window therefore still see a low ready. The bench then requires that `rst_out` falls and `rdy_out` rises on one and the same edge, with the edge before it showing reset still high and ready still low. A cycle-accurate reference model in the bench also predicts both outputs on every cycle. So an update that comes one `phi2` pulse early or late is reported against R7 or R8.

// File: rtl/phase_clkgen_pkg.sv
package phase_clkgen_pkg;

    // Phase sequencer states, in the order they are visited.
    typedef enum logic [1:0] {
        SEQ_P1   = 2'd0,
        SEQ_GAP1 = 2'd1,
        SEQ_P2   = 2'd2,
        SEQ_GAP2 = 2'd3
    } seq_state_e;

    // Reset conditioner states.
    typedef enum logic [1:0] {
        RC_SYNC = 2'd0,
        RC_HOLD = 2'd1,
        RC_RUN  = 2'd2
    } rst_state_e;

endpackage

// File: rtl/phase_seq.sv
module phase_seq
    import phase_clkgen_pkg::*;
#(
    parameter int DIV    = 9,
    parameter int P1_LEN = 2,
    parameter int P2_LEN = 5
) (
    input  logic clk,
    output logic phi1,
    output logic phi2,
    output logic sys_clk,
    output logic p2_enter
);
    localparam int CW       = $clog2(DIV);
    localparam int P2_START = P1_LEN + 1;
    localparam int P2_END   = P2_START + P2_LEN - 1;
    localparam int HALF     = (DIV + 1) / 2;

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    seq_state_e    state;
    seq_state_e    state_nxt;

    // Free-running modulo-DIV count; any out-of-range value recovers to 0.
    always_comb begin
        if (cnt >= CW'(DIV - 1)) cnt_nxt = '0;
        else                     cnt_nxt = cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        cnt <= cnt_nxt;
    end

    // Next phase state from the next count.
    always_comb begin
        if (cnt_nxt < CW'(P1_LEN))         state_nxt = SEQ_P1;
        else if (cnt_nxt < CW'(P2_START))  state_nxt = SEQ_GAP1;
        else if (cnt_nxt <= CW'(P2_END))   state_nxt = SEQ_P2;
        else                               state_nxt = SEQ_GAP2;
    end

    // State register.
    always_ff @(posedge clk) begin
        state <= state_nxt;
    end

    // Registered outputs: each phase comes straight from a flop.
    always_ff @(posedge clk) begin
        unique case (state_nxt)
            SEQ_P1:   begin phi1 <= 1'b1; phi2 <= 1'b0; end
            SEQ_GAP1: begin phi1 <= 1'b0; phi2 <= 1'b0; end
            SEQ_P2:   begin phi1 <= 1'b0; phi2 <= 1'b1; end
            SEQ_GAP2: begin phi1 <= 1'b0; phi2 <= 1'b0; end
        endcase
        sys_clk <= (cnt_nxt < CW'(HALF));
    end

    // High during the cycle that ends in a phi2 rising edge.
    assign p2_enter = (state_nxt == SEQ_P2) && (state != SEQ_P2);

endmodule

// File: rtl/rst_cond.sv
module rst_cond
    import phase_clkgen_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int DIV    = 9
) (
    input  logic clk,
    input  logic rst_req,
    input  logic p2_enter,
    output logic rst_out
);
    localparam int HW = $clog2(DIV + 1);

    logic [STAGES-1:0] sr;
    logic              rst_s;
    logic [HW-1:0]     hold;
    logic              hold_done;
    rst_state_e        state;
    rst_state_e        state_nxt;

    // Asynchronous assert, synchronous release.
    always_ff @(posedge clk or posedge rst_req) begin
        if (rst_req) sr <= '1;
        else         sr <= {sr[STAGES-2:0], 1'b0};
    end
    assign rst_s = sr[STAGES-1];

    assign hold_done = (hold == HW'(DIV));

    always_comb begin
        unique case (state)
            RC_SYNC: state_nxt = rst_s ? RC_SYNC : RC_HOLD;
            RC_HOLD: begin
                if (rst_s)                       state_nxt = RC_SYNC;
                else if (hold_done && p2_enter)  state_nxt = RC_RUN;
                else                             state_nxt = RC_HOLD;
            end
            RC_RUN:  state_nxt = rst_s ? RC_SYNC : RC_RUN;
            default: state_nxt = RC_SYNC;
        endcase
    end

    // State register.
    always_ff @(posedge clk or posedge rst_req) begin
        if (rst_req) state <= RC_SYNC;
        else         state <= state_nxt;
    end

    // Hold-time counter, saturating at one full period.
    always_ff @(posedge clk or posedge rst_req) begin
        if (rst_req)                    hold <= '0;
        else if (state_nxt != RC_HOLD)  hold <= '0;
        else if (!hold_done)            hold <= hold + 1'b1;
    end

    // Output register.
    always_ff @(posedge clk or posedge rst_req) begin
        if (rst_req) begin
            rst_out <= 1'b1;
        end else begin
            unique case (state_nxt)
                RC_RUN:  rst_out <= 1'b0;
                default: rst_out <= 1'b1;
            endcase
        end
    end

    // R7: reset never releases before the hold counter has completed.
    assert_hold_before_release_R7: assert property (@(posedge clk) disable iff (rst_req)
        $fell(rst_out) |-> $past(hold) == HW'(DIV));

endmodule

// File: rtl/rdy_cond.sv
module rdy_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_req,
    input  logic rdy_raw,
    input  logic p2_enter,
    output logic rdy_out
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk or posedge rst_req) begin
        if (rst_req) sr <= '0;
        else         sr <= {sr[STAGES-2:0], rdy_raw};
    end

    always_ff @(posedge clk or posedge rst_req) begin
        if (rst_req)       rdy_out <= 1'b0;
        else if (p2_enter) rdy_out <= sr[STAGES-1];
    end

    // R9: ready stays low while reset is requested.
    assert_rdy_low_in_reset_R9: assert property (@(posedge clk)
        rst_req |-> !rdy_out);

endmodule

// File: rtl/phase_clkgen.sv
module phase_clkgen #(
    parameter int DIV         = 9,
    parameter int P1_LEN      = 2,
    parameter int P2_LEN      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_req,
    input  logic rdy_raw,
    output logic phi1,
    output logic phi2,
    output logic sys_clk,
    output logic rst_out,
    output logic rdy_out
);
    localparam int RW = $clog2(DIV + 1);

    logic p2_enter;

    phase_seq #(.DIV(DIV), .P1_LEN(P1_LEN), .P2_LEN(P2_LEN)) seq_i (
        .clk      (ref_clk),
        .phi1     (phi1),
        .phi2     (phi2),
        .sys_clk  (sys_clk),
        .p2_enter (p2_enter)
    );

    rst_cond #(.STAGES(SYNC_STAGES), .DIV(DIV)) rst_i (
        .clk      (ref_clk),
        .rst_req  (rst_req),
        .p2_enter (p2_enter),
        .rst_out  (rst_out)
    );

    rdy_cond #(.STAGES(SYNC_STAGES)) rdy_i (
        .clk      (ref_clk),
        .rst_req  (rst_req),
        .rdy_raw  (rdy_raw),
        .p2_enter (p2_enter),
        .rdy_out  (rdy_out)
    );

    // Checker state: run lengths of each phase and spacing of phi1 rises.
    logic [RW-1:0] p1_run;
    logic [RW-1:0] p2_run;
    logic [RW:0]   per;
    logic          phi1_d;

    always_ff @(posedge ref_clk) begin
        p1_run <= phi1 ? p1_run + 1'b1 : '0;
        p2_run <= phi2 ? p2_run + 1'b1 : '0;
        phi1_d <= phi1;
        if (phi1 && !phi1_d)  per <= (RW+1)'(1);
        else if (per != '1)   per <= per + 1'b1;
    end

    assert_no_overlap_R2: assert property (@(posedge ref_clk) disable iff (rst_req)
        !(phi1 && phi2));
    assert_gap_after_p1_R2: assert property (@(posedge ref_clk) disable iff (rst_req)
        $fell(phi1) |-> !phi2);
    assert_gap_after_p2_R2: assert property (@(posedge ref_clk) disable iff (rst_req)
        $fell(phi2) |-> !phi1);
    assert_p1_width_R3: assert property (@(posedge ref_clk) disable iff (rst_req)
        $fell(phi1) |-> p1_run == RW'(P1_LEN));
    assert_p2_width_R4: assert property (@(posedge ref_clk) disable iff (rst_req)
        $fell(phi2) |-> p2_run == RW'(P2_LEN));
    assert_period_R1: assert property (@(posedge ref_clk) disable iff (rst_req)
        (phi1 && !phi1_d) |-> per == (RW+1)'(DIV));
    assert_sys_align_R5: assert property (@(posedge ref_clk) disable iff (rst_req)
        $rose(sys_clk) |-> $rose(phi1));
    assert_rst_on_phase_R7: assert property (@(posedge ref_clk) disable iff (rst_req)
        $fell(rst_out) |-> $rose(phi2));
    assert_rdy_on_phase_R8: assert property (@(posedge ref_clk) disable iff (rst_req)
        !$stable(rdy_out) |-> $rose(phi2));

endmodule

// File: tb/phase_clkgen_tb_top.sv
module phase_clkgen_tb_top;

    localparam int DIV = 9;

    logic clk = 1'b0;
    logic rst_req;
    logic rdy_raw;
    logic phi1, phi2, sys_clk, rst_out, rdy_out;

    always #10 clk = ~clk;

    phase_clkgen dut_i (
        .ref_clk (clk),
        .rst_req (rst_req),
        .rdy_raw (rdy_raw),
        .phi1    (phi1),
        .phi2    (phi2),
        .sys_clk (sys_clk),
        .rst_out (rst_out),
        .rdy_out (rdy_out)
    );

    typedef struct {
        bit chk;
        bit p1, p2, sc, rst, rdy, rel;
        int ph;
    } exp_t;

    exp_t q[$];
    int   vectors = 0;
    int   errors  = 0;
    bit   done    = 0;

    // Reference model state.
    bit locked = 0;
    int ph = 0;
    int since = 0;
    bit released = 0;
    bit exp_rdy = 0;
    bit h0 = 0, h1 = 0, h2 = 0;
    bit phi2_prev = 0;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Model: runs just after each edge, pushes the expected outputs.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (rst_req) begin h0 = 0; h1 = 0; h2 = 0; end
        else begin h2 = h1; h1 = h0; h0 = rdy_raw; end
        if (locked) ph = (ph + 1) % DIV;
        else if (phi2 && !phi2_prev) begin locked = 1; ph = 3; end
        phi2_prev = phi2;
        e.rel = 0;
        if (rst_req) begin
            since = 0; released = 0; exp_rdy = 0;
        end else begin
            since++;
            if (!released && locked && ph == 3 && since >= DIV + 3) begin
                released = 1; e.rel = 1;
            end
            if (locked && ph == 3) exp_rdy = h2;
        end
        e.chk = locked;
        e.ph  = ph;
        e.p1  = (ph < 2);
        e.p2  = (ph >= 3 && ph <= 7);
        e.sc  = (ph < 5);
        e.rst = !released;
        e.rdy = exp_rdy;
        q.push_back(e);
    end

    // Monitor: pops one expectation per cycle and compares away from the edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.chk) begin
                if (rst_req) begin e.rst = 1; e.rdy = 0; end
                check(!(phi1 && phi2), "R2 overlap", phi1 & phi2, 0);
                check(phi1 == e.p1, "R1 R3 phi1", phi1, e.p1);
                check(phi2 == e.p2, "R1 R4 phi2", phi2, e.p2);
                check(sys_clk == e.sc, "R5 sys_clk", sys_clk, e.sc);
                check(rst_out == e.rst, e.rel ? "R7 release" : "R6 R7 rst_out", rst_out, e.rst);
                check(rdy_out == e.rdy, rst_req ? "R9 rdy_out" : "R8 rdy_out", rdy_out, e.rdy);
            end
        end
    end

    task automatic drv_rdy(input bit v);
        @(posedge clk); #5; rdy_raw = v;
    endtask

    task automatic drv_rst(input bit v);
        @(posedge clk); #5; rst_req = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        finish_run();
    end

    initial begin
        bit prev_rst, prev_rdy;
        rst_req = 1'b1;
        rdy_raw = 1'b0;
        wait_cyc(20);
        // Reset state: R6, R9
        check(rst_out == 1'b1, "R6 reset state", rst_out, 1);
        check(rdy_out == 1'b0, "R9 reset state", rdy_out, 0);
        check(locked, "R1 phase lock", locked, 1);

        // Release with a ready rise that lands on the release edge (R7 with R8).
        drv_rst(0);
        @(negedge clk);
        while (!(since >= DIV && ph == 0)) @(negedge clk);
        rdy_raw = 1'b1;
        prev_rst = rst_out; prev_rdy = rdy_out;
        for (int i = 0; i < 30 && rst_out; i++) begin
            prev_rst = rst_out; prev_rdy = rdy_out;
            @(negedge clk);
        end
        check(rst_out == 0, "R7 released", rst_out, 0);
        check(prev_rst == 1 && prev_rdy == 0, "R7 R8 state before shared edge", {prev_rst, prev_rdy}, 2);
        check(rdy_out == 1, "R8 ready on release edge", rdy_out, 1);
        check(phi2 == 1 && ph == 3, "R7 release at phi2 start", ph, 3);

        wait_cyc(40);
        drv_rdy(0);
        wait_cyc(40);

        // Short ready pulse between sampling points is ignored (R8).
        while (ph != 4) @(negedge clk);
        rdy_raw = 1'b1;
        wait_cyc(2);
        rdy_raw = 1'b0;
        while (ph != 3) @(negedge clk);
        check(rdy_out == 0, "R8 short pulse ignored", rdy_out, 0);

        // Changing ready pattern.
        for (int i = 0; i < 20; i++) begin
            drv_rdy(i[0]);
            repeat (6) @(posedge clk);
        end

        // Mid-run reset with ready high: R6, R9, clocks keep running (R1).
        drv_rdy(1);
        wait_cyc(15);
        drv_rst(1);
        @(negedge clk);
        check(rst_out == 1, "R6 async assert", rst_out, 1);
        check(rdy_out == 0, "R9 ready cleared", rdy_out, 0);
        wait_cyc(6);
        drv_rst(0);
        wait_cyc(40);
        check(rst_out == 0, "R7 released again", rst_out, 0);
        check(rdy_out == 1, "R8 ready after reset", rdy_out, 1);
        wait_cyc(50);
        finish_run();
    end

endmodule